// File: doc/BRIEF.md
# Hexagonal Region-Growth Array with Merge Blocking

The block is a synchronous two-dimensional array of identical vertex cells on a hexagonal lattice whose edges wrap around in both directions, so the lattice is a torus. Each vertex holds one state bit: filled or empty. Software-visible seeds are first written into the array one row per cycle. Then, on each step cycle, every vertex updates in parallel. Filled regions spread into adjacent vertices, but a vertex refuses to fill when filling it would join two regions that are locally distinct. When no vertex changes any more, the filled areas are the Voronoi cells of the seeds. Each pair of neighbouring cells is left separated by one or two empty vertices.

Two local tests do the blocking. An empty vertex is a joining vertex when the filled vertices in its ring of six neighbours form two or more separate runs. An empty edge is a joining edge when each of its ends touches a filled vertex while the edge's two apex vertices are empty. Any empty vertex that is a joining vertex, or an end of a joining edge, is held empty for that step. An optional pseudo-random skip makes some vertices keep their old value in a step, which gives a perturbed diagram. A converged flag reports that a step would leave every vertex unchanged.

Top module: `hexgrow_array`

## Requirements
- R1: After reset, every bit of `field_o` is 0 and `converged_o` is 0.
- R2: In a cycle with `load_en` high, `load_bits[c]` is written to vertex (`load_row`, c). That vertex is bit `load_row*COLS+c` of `field_o`. Other rows keep their values, `converged_o` clears, and `step_en` has no effect in that cycle.
- R3: The neighbours of vertex (r,c) are (r,c+1), (r-1,c+1), (r-1,c), (r,c-1), (r+1,c-1) and (r+1,c). Row indices wrap modulo ROWS and column indices wrap modulo COLS. That list is also the cyclic ring order used by R5.
- R4: In a step cycle (`step_en` high, `load_en` low) with skipping off, a vertex becomes 1 if it or any neighbour is 1, unless it is held empty under R5 or R6.
- R5: An empty vertex whose six neighbours, taken in ring order, contain two or more separate runs of filled vertices stays empty.
- R6: Take two adjacent empty vertices that each have a filled neighbour. If both of their common neighbours are empty, both vertices stay empty.
- R7: A filled vertex never becomes empty in a step.
- R8: In a cycle with `load_en` and `step_en` both low, `field_o` and `converged_o` hold their values.
- R9: After a step cycle, `converged_o` is 1 exactly when the R4 update without skipping equals the state before that step.
- R10: With `skip_en` high, each vertex in a step either takes its R4 value or keeps its old value. It keeps the old value with a probability of about 2^-SKIP_BITS. With `skip_en` low, no vertex skips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one row of seeds this cycle |
| load_row | input | $clog2(ROWS) | Row index to write |
| load_bits | input | COLS | Seed bits for the row, bit c is column c |
| step_en | input | 1 | Advance every vertex by one update |
| skip_en | input | 1 | Enable pseudo-random per-vertex update skipping |
| field_o | output | ROWS*COLS | Registered state bits, vertex (r,c) at bit r*COLS+c |
| converged_o | output | 1 | Last step would change no vertex |

## Verification
Seed loading and growth can be requested in the same cycle. The bench provokes this by raising `load_en` and `step_en` together after the array has converged. It then judges that the loaded row holds exactly the new bits, that every other row matches the converged picture with no growth applied, and that `converged_o` has dropped. A second collision comes from two regions reaching one vertex in the same step. Seeds placed two and three vertices apart produce it, and the bench confirms that the joining vertex and the joining edge stay empty through convergence.

// File: rtl/hexgrow_pkg.sv
package hexgrow_pkg;
  localparam int RING = 6;

  // Number of empty-to-filled transitions walking once around the ring.
  function automatic logic [2:0] run_starts(input logic [RING-1:0] ring);
    logic [2:0] n;
    n = '0;
    for (int k = 0; k < RING; k++) begin
      if (!ring[k] && ring[(k + 1) % RING]) n = n + 3'd1;
    end
    return n;
  endfunction
endpackage

// File: rtl/hexgrow_cell.sv
module hexgrow_cell
  import hexgrow_pkg::*;
(
  input  logic            self_bit,
  input  logic            self_front,
  input  logic [RING-1:0] ring,
  input  logic [RING-1:0] ring_front,
  output logic            next_bit
);
  logic [RING-1:0] join_edge;
  logic            join_vertex;
  logic            hold_empty;

  // Edge to ring member k: its apexes are ring members k-1 and k+1.
  for (genvar k = 0; k < RING; k++) begin : g_edge
    localparam int KP = (k + 1) % RING;
    localparam int KM = (k + RING - 1) % RING;
    assign join_edge[k] = ~ring[k] & ~ring[KP] & ~ring[KM] & self_front & ring_front[k];
  end

  assign join_vertex = (run_starts(ring) >= 3'd2);
  assign hold_empty  = ~self_bit & (join_vertex | (|join_edge));
  assign next_bit    = (self_bit | (|ring)) & ~hold_empty;
endmodule

// File: rtl/hexgrow_skip.sv
module hexgrow_skip #(
  parameter int          N         = 64,
  parameter int          SKIP_BITS = 4,
  parameter int          LFSR_W    = 32,
  parameter logic [31:0] TAPS      = 32'hA300_0000,
  parameter logic [31:0] SEED      = 32'h1D2C_3B4A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         skip_en,
  output logic [N-1:0] skip_v
);
  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= SEED[LFSR_W-1:0];
    else     lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS[LFSR_W-1:0] : '0);
  end

  for (genvar i = 0; i < N; i++) begin : g_vert
    logic [SKIP_BITS-1:0] pick;
    for (genvar j = 0; j < SKIP_BITS; j++) begin : g_bit
      assign pick[j] = lfsr_q[(i * 7 + j * 11) % LFSR_W];
    end
    assign skip_v[i] = skip_en & (&pick);
  end
endmodule

// File: rtl/hexgrow_array.sv
module hexgrow_array
  import hexgrow_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int COLS      = 64,
  parameter int SKIP_BITS = 4,
  localparam int N        = ROWS * COLS,
  localparam int RW       = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [RW-1:0] load_row,
  input  logic [COLS-1:0] load_bits,
  input  logic          step_en,
  input  logic          skip_en,
  output logic [N-1:0]  field_o,
  output logic          converged_o
);
  logic [N-1:0] state_q;
  logic         conv_q;
  logic [N-1:0] front;
  logic [N-1:0] nxt_full;
  logic [N-1:0] nxt_eff;
  logic [N-1:0] skip_v;

  hexgrow_skip #(.N(N), .SKIP_BITS(SKIP_BITS)) u_skip (
    .clk(clk), .rst(rst), .skip_en(skip_en), .skip_v(skip_v)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int RM = (r + ROWS - 1) % ROWS;
      localparam int RP = (r + 1) % ROWS;
      localparam int CM = (c + COLS - 1) % COLS;
      localparam int CP = (c + 1) % COLS;
      localparam int I  = r * COLS + c;
      localparam int N0 = r  * COLS + CP;
      localparam int N1 = RM * COLS + CP;
      localparam int N2 = RM * COLS + c;
      localparam int N3 = r  * COLS + CM;
      localparam int N4 = RP * COLS + CM;
      localparam int N5 = RP * COLS + c;
      logic [RING-1:0] ring_w;
      logic [RING-1:0] ring_f;
      assign ring_w = {state_q[N5], state_q[N4], state_q[N3],
                       state_q[N2], state_q[N1], state_q[N0]};
      assign ring_f = {front[N5], front[N4], front[N3],
                       front[N2], front[N1], front[N0]};
      assign front[I] = |ring_w;
      hexgrow_cell u_cell (
        .self_bit(state_q[I]), .self_front(front[I]),
        .ring(ring_w), .ring_front(ring_f), .next_bit(nxt_full[I])
      );
      assign nxt_eff[I] = skip_v[I] ? state_q[I] : nxt_full[I];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      conv_q  <= 1'b0;
    end else if (load_en) begin
      if (int'(load_row) < ROWS) state_q[int'(load_row) * COLS +: COLS] <= load_bits;
      conv_q <= 1'b0;
    end else if (step_en) begin
      state_q <= nxt_eff;
      conv_q  <= (nxt_full == state_q);
    end
  end

  assign field_o     = state_q;
  assign converged_o = conv_q;
endmodule

// File: rtl/hexgrow_checker.sv
module hexgrow_checker #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         load_en,
  input logic         step_en,
  input logic [N-1:0] state,
  input logic         converged
);
  // R1: reset leaves an empty field and a low flag
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (state == '0 && !converged));

  // R7: a step never empties a filled vertex
  p_monotone_r7: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> ((state & $past(state)) == $past(state)));

  // R8: idle cycles hold everything
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load_en) |=> ($stable(state) && $stable(converged)));

  // R2 / R9: a load drops the flag
  p_load_clears_r9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !converged);

  // R9: a step that raises the flag changed nothing
  p_conv_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en) |=> (!converged || state == $past(state)));
endmodule

bind hexgrow_array hexgrow_checker #(.N(N)) u_hexgrow_checker (
  .clk(clk), .rst(rst), .load_en(load_en), .step_en(step_en),
  .state(state_q), .converged(conv_q)
);

// File: tb/hexgrow_array_bench.sv
module hexgrow_array_bench;
  localparam int R  = 6;
  localparam int C  = 8;
  localparam int N  = R * C;
  localparam int RW = $clog2(R);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [RW-1:0] load_row = '0;
  logic [C-1:0]  load_bits = '0;
  logic          step_en = 1'b0;
  logic          skip_en = 1'b0;
  logic [N-1:0]  field_o;
  logic          converged_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hexgrow_array #(.ROWS(R), .COLS(C), .SKIP_BITS(2)) u_hexgrow_array (
    .clk(clk), .rst(rst), .load_en(load_en), .load_row(load_row),
    .load_bits(load_bits), .step_en(step_en), .skip_en(skip_en),
    .field_o(field_o), .converged_o(converged_o)
  );

  // Neighbour k of vertex i in ring order from R3.
  function automatic int nb(int i, int k);
    int r = i / C;
    int c = i % C;
    int dr = 0;
    int dc = 0;
    case (k)
      0: begin dr = 0;  dc = 1;  end
      1: begin dr = -1; dc = 1;  end
      2: begin dr = -1; dc = 0;  end
      3: begin dr = 0;  dc = -1; end
      4: begin dr = 1;  dc = -1; end
      default: begin dr = 1; dc = 0; end
    endcase
    return ((r + dr + R) % R) * C + ((c + dc + C) % C);
  endfunction

  function automatic bit touches(logic [N-1:0] s, int i);
    bit t = 1'b0;
    for (int k = 0; k < 6; k++) if (s[nb(i, k)]) t = 1'b1;
    return t;
  endfunction

  // Expected update from R4, R5, R6.
  function automatic logic [N-1:0] expect_step(logic [N-1:0] s);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) begin
      if (s[i]) o[i] = 1'b1;
      else begin
        int runs = 0;
        bit blocked = 1'b0;
        for (int k = 0; k < 6; k++)
          if (!s[nb(i, k)] && s[nb(i, (k + 1) % 6)]) runs++;
        if (runs >= 2) blocked = 1'b1;
        for (int k = 0; k < 6; k++)
          if (!s[nb(i, k)] && !s[nb(i, (k + 1) % 6)] && !s[nb(i, (k + 5) % 6)]
              && touches(s, i) && touches(s, nb(i, k))) blocked = 1'b1;
        o[i] = touches(s, i) && !blocked;
      end
    end
    return o;
  endfunction

  task automatic check(bit ok, string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_field(logic [N-1:0] f);
    for (int r = 0; r < R; r++) begin
      load_en = 1'b1;
      load_row = RW'(r);
      load_bits = f[r * C +: C];
      tick();
    end
    load_en = 1'b0;
  endtask

  // One exact step, checked against R4, R7, R9.
  task automatic exact_step();
    logic [N-1:0] pre;
    logic [N-1:0] exp;
    pre = field_o;
    exp = expect_step(pre);
    step_en = 1'b1;
    tick();
    step_en = 1'b0;
    check(field_o == exp, "R4", "step result", field_o, exp);
    check((field_o & pre) == pre, "R7", "monotone", field_o, pre);
    check(converged_o == (exp == pre), "R9", "converged flag",
          N'(converged_o), N'(exp == pre));
  endtask

  task automatic run_to_conv();
    for (int n = 0; n < 30 && !converged_o; n++) exact_step();
    check(converged_o == 1'b1, "R9", "reached convergence", N'(converged_o), N'(1));
  endtask

  initial begin
    logic [N-1:0] f;
    logic [N-1:0] e;
    logic [N-1:0] pre;
    logic [N-1:0] full;
    int skipped;

    repeat (3) tick();
    check(field_o == '0, "R1", "field after reset", field_o, '0);
    check(converged_o == 1'b0, "R1", "flag after reset", N'(converged_o), '0);
    rst = 1'b0;
    tick();

    // R2 and R3: single seed at the corner wraps round both axes
    f = '0;
    f[0] = 1'b1;
    load_field(f);
    check(field_o == f, "R2", "loaded corner seed", field_o, f);
    exact_step();
    e = '0;
    e[0] = 1'b1; e[1] = 1'b1; e[7] = 1'b1; e[8] = 1'b1;
    e[15] = 1'b1; e[40] = 1'b1; e[41] = 1'b1;
    check(field_o == e, "R3", "toroidal neighbours", field_o, e);

    // R8: idle holds the field and the flag
    pre = field_o;
    repeat (5) tick();
    check(field_o == pre, "R8", "idle field", field_o, pre);
    check(converged_o == 1'b0, "R8", "idle flag", N'(converged_o), '0);

    // R5: seeds two apart leave the middle vertex empty
    f = '0;
    f[17] = 1'b1; f[19] = 1'b1;
    load_field(f);
    check(converged_o == 1'b0, "R2", "load clears flag", N'(converged_o), '0);
    run_to_conv();
    check(field_o[18] == 1'b0, "R5", "joining vertex stays empty", field_o, f);

    // R6: seeds three apart leave the joining edge empty
    f = '0;
    f[25] = 1'b1; f[28] = 1'b1;
    load_field(f);
    run_to_conv();
    check(field_o[26] == 1'b0 && field_o[27] == 1'b0, "R6",
          "joining edge ends stay empty", field_o, f);

    // R4: three scattered seeds converge against the expected rule
    f = '0;
    f[0] = 1'b1; f[20] = 1'b1; f[45] = 1'b1;
    load_field(f);
    run_to_conv();

    // R2: load and step in the same cycle, load wins
    pre = field_o;
    load_en = 1'b1;
    step_en = 1'b1;
    load_row = '0;
    load_bits = 8'hA5;
    tick();
    load_en = 1'b0;
    step_en = 1'b0;
    e = pre;
    e[0 +: C] = 8'hA5;
    check(field_o == e, "R2", "load beats step", field_o, e);
    check(converged_o == 1'b0, "R2", "collision clears flag", N'(converged_o), '0);

    // R10: skipping on, each vertex keeps old or takes the exact value
    f = '0;
    f[3] = 1'b1; f[30] = 1'b1;
    load_field(f);
    skip_en = 1'b1;
    skipped = 0;
    for (int n = 0; n < 200 && !converged_o; n++) begin
      pre = field_o;
      full = expect_step(pre);
      step_en = 1'b1;
      tick();
      step_en = 1'b0;
      check(((field_o ^ pre) & ~(full ^ pre)) == '0 && ((field_o ^ full) & ~(full ^ pre)) == '0,
            "R10", "vertex kept or updated", field_o, full);
      check(converged_o == (full == pre), "R9", "flag under skipping",
            N'(converged_o), N'(full == pre));
      if (field_o != full) skipped++;
    end
    skip_en = 1'b0;
    check(skipped > 0, "R10", "some vertex skipped", N'(skipped), N'(1));
    check(expect_step(field_o) == field_o, "R10", "final field is stable",
          field_o, expect_step(field_o));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule